// File: doc/BRIEF.md
# Processor Sleep State Controller

This block moves the processor into a low-power state when software reads one of two trigger registers, and brings it back when an interrupt-class event arrives. A read of the light trigger drives the active-low stop-clock output low. A read of the deep trigger does the same, and can also stop the CPU clock and assert the sleep pin, depending on two enable inputs sampled at the moment of the read.

Wake comes from any of three inputs: maskable interrupt, system-management interrupt or ACPI system-control interrupt. Leaving the light state frees stop-clock at once. Leaving the deep state frees the outputs in the reverse of their assertion order: sleep first, then CPU-clock-stop, then stop-clock, with a fixed gap of `RELEASE_GAP` clocks between steps. The register port is a simple strobe interface. The trigger registers always read as zero, and writes do nothing.

Top module: `cpu_sleep_ctl`

## Requirements
- R1: A read strobe at address 4 (light trigger), taken while running, drives `stpclk_n` low on the next clock. `cpustp_n` and `slp_n` stay high.
- R2: A read strobe at address 5 (deep trigger), taken while running, drives `stpclk_n` low on the next clock.
- R3: In the deep state, `cpustp_n` is low if and only if `clkstop_en` was 1 in the cycle of the trigger read. Later changes to `clkstop_en` have no effect.
- R4: In the deep state, `slp_n` is low if and only if `sleep_en` was 1 in the cycle of the trigger read. Later changes to `sleep_en` have no effect.
- R5: Any one of `wake_intr`, `wake_smi` or `wake_sci`, seen in the light state, returns `stpclk_n` high on the next clock.
- R6: `reg_rdata` is all zeros for every read. A write strobe at either trigger address changes no output.
- R7: Let W be the clock that samples a wake in the deep state. `slp_n` goes high on clock W. `cpustp_n` goes high on clock W+RELEASE_GAP. `stpclk_n` goes high on clock W+2*RELEASE_GAP. RELEASE_GAP defaults to 4.
- R8: A trigger read is ignored while in a stop state or while the release sequence runs. A wake input is ignored while running.
- R9: After reset the block is running, with all three active-low outputs high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W | Register offset |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data (ignored) |
| reg_rdata | output | DATA_W | Read data, always zero |
| clkstop_en | input | 1 | Stop CPU clock in deep state |
| sleep_en | input | 1 | Assert sleep pin in deep state |
| wake_intr | input | 1 | Maskable interrupt wake |
| wake_smi | input | 1 | System-management interrupt wake |
| wake_sci | input | 1 | System-control interrupt wake |
| stpclk_n | output | 1 | Stop-clock request, active low |
| cpustp_n | output | 1 | CPU clock stop, active low |
| slp_n | output | 1 | Sleep, active low |

## Verification
A wrong internal state shows up at the three outputs one clock after the event that caused it. Examples are a missed trigger, a wake taken while running, and a deep state that latched the wrong enable. The release counter is the exception, because an error there only shows at a release step. A gap that is too short or too long moves a rising edge of `cpustp_n` or `stpclk_n` off its expected clock. A release order that is wrong breaks the rule that sleep and CPU-clock-stop are never low while stop-clock is high.

// File: rtl/cpu_sleep_ctl.sv
module cpu_sleep_ctl #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int L2_ADDR     = 4,
  parameter int L3_ADDR     = 5,
  parameter int RELEASE_GAP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              clkstop_en,
  input  logic              sleep_en,
  input  logic              wake_intr,
  input  logic              wake_smi,
  input  logic              wake_sci,
  output logic              stpclk_n,
  output logic              cpustp_n,
  output logic              slp_n
);
  localparam int CNT_W = $clog2(RELEASE_GAP + 1);
  localparam logic [CNT_W-1:0] GAP = CNT_W'(RELEASE_GAP);

  typedef enum logic [2:0] {S_RUN, S_L2, S_L3, S_REL_CPU, S_REL_STP} st_t;

  st_t             state;
  logic [CNT_W-1:0] cnt;

  wire wake   = wake_intr | wake_smi | wake_sci;
  wire trig2  = reg_rd && (reg_addr == ADDR_W'(L2_ADDR));
  wire trig3  = reg_rd && (reg_addr == ADDR_W'(L3_ADDR));
  wire last   = (cnt == CNT_W'(1));
  wire unused_ok = &{1'b0, reg_wr, reg_wdata};

  assign reg_rdata = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_RUN;
      cnt      <= '0;
      stpclk_n <= 1'b1;
      cpustp_n <= 1'b1;
      slp_n    <= 1'b1;
    end else begin
      case (state)
        S_RUN:
          if (trig2) begin
            state    <= S_L2;
            stpclk_n <= 1'b0;
          end else if (trig3) begin
            state    <= S_L3;
            stpclk_n <= 1'b0;
            cpustp_n <= ~clkstop_en;
            slp_n    <= ~sleep_en;
          end
        S_L2:
          if (wake) begin
            state    <= S_RUN;
            stpclk_n <= 1'b1;
          end
        S_L3:
          if (wake) begin
            state <= S_REL_CPU;
            slp_n <= 1'b1;
            cnt   <= GAP;
          end
        S_REL_CPU:
          if (last) begin
            state    <= S_REL_STP;
            cpustp_n <= 1'b1;
            cnt      <= GAP;
          end else begin
            cnt <= cnt - 1'b1;
          end
        S_REL_STP:
          if (last) begin
            state    <= S_RUN;
            stpclk_n <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        default: state <= S_RUN;
      endcase
    end
  end
endmodule

module cpu_sleep_ctl_chk #(
  parameter int ADDR_W  = 4,
  parameter int L2_ADDR = 4,
  parameter int L3_ADDR = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_rd,
  input logic              clkstop_en,
  input logic              sleep_en,
  input logic              wake,
  input logic [2:0]        st,
  input logic              stpclk_n,
  input logic              cpustp_n,
  input logic              slp_n
);
  localparam logic [2:0] RUN = 3'd0;
  localparam logic [2:0] L2  = 3'd1;

  wire go2 = st == RUN && reg_rd && reg_addr == ADDR_W'(L2_ADDR);
  wire go3 = st == RUN && reg_rd && reg_addr == ADDR_W'(L3_ADDR);

  assert_l2_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    go2 |=> !stpclk_n && cpustp_n && slp_n);
  assert_l3_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go3 |=> !stpclk_n);
  assert_clkstop_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    go3 |=> cpustp_n == !$past(clkstop_en));
  assert_sleep_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    go3 |=> slp_n == !$past(sleep_en));
  assert_l2_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st == L2 && wake |=> stpclk_n);
  assert_release_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!slp_n || !cpustp_n) |-> !stpclk_n);
  assert_cpu_before_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpustp_n) |-> slp_n);
  assert_idle_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st == RUN && !reg_rd && stpclk_n |=> stpclk_n && cpustp_n && slp_n);
  assert_stop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st == L2 && !wake |=> !stpclk_n && cpustp_n && slp_n);
endmodule

bind cpu_sleep_ctl cpu_sleep_ctl_chk #(
  .ADDR_W(ADDR_W), .L2_ADDR(L2_ADDR), .L3_ADDR(L3_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
  .clkstop_en(clkstop_en), .sleep_en(sleep_en), .wake(wake),
  .st(state), .stpclk_n(stpclk_n), .cpustp_n(cpustp_n), .slp_n(slp_n)
);

// File: tb/cpu_sleep_ctl_test.sv
module cpu_sleep_ctl_test;
  localparam int GAP = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  reg_addr = '0;
  logic        reg_rd = 0, reg_wr = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        clkstop_en = 0, sleep_en = 0;
  logic        wake_intr = 0, wake_smi = 0, wake_sci = 0;
  logic        stpclk_n, cpustp_n, slp_n;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  cpu_sleep_ctl uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .clkstop_en(clkstop_en), .sleep_en(sleep_en),
    .wake_intr(wake_intr), .wake_smi(wake_smi), .wake_sci(wake_sci),
    .stpclk_n(stpclk_n), .cpustp_n(cpustp_n), .slp_n(slp_n)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  function automatic logic [2:0] outs_l3(logic cen, logic sen);
    return {1'b0, ~cen, ~sen};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic rd_pulse(logic [3:0] a, string req);
    reg_addr = a; reg_rd = 1;
    #1 chk({req, " R6 rdata"}, reg_rdata, 32'h0);
    step();
    reg_rd = 0;
  endtask

  task automatic wake_pulse(int src);
    wake_intr = (src == 0); wake_smi = (src == 1); wake_sci = (src == 2);
    step();
    {wake_intr, wake_smi, wake_sci} = '0;
  endtask

  task automatic idle(int n, logic [2:0] exp, string req);
    for (int i = 0; i < n; i++) begin
      clkstop_en = 1'($urandom); sleep_en = 1'($urandom);
      step();
      chk(req, {stpclk_n, cpustp_n, slp_n}, exp);
    end
  endtask

  task automatic run_l2(int src, int hold, bit spur);
    rd_pulse(4'd4, "R1");
    chk("R1 light entry", {stpclk_n, cpustp_n, slp_n}, 3'b011);
    idle(hold, 3'b011, "R8 light hold");
    if (spur) begin
      rd_pulse(4'(4 + ($urandom % 2)), "R8");
      chk("R8 read in light state", {stpclk_n, cpustp_n, slp_n}, 3'b011);
    end
    wake_pulse(src);
    chk("R5 light wake", {stpclk_n, cpustp_n, slp_n}, 3'b111);
  endtask

  task automatic run_l3(logic cen, logic sen, int src, int hold, bit spur);
    clkstop_en = cen; sleep_en = sen;
    rd_pulse(4'd5, "R2");
    chk("R2 R3 R4 deep entry", {stpclk_n, cpustp_n, slp_n}, outs_l3(cen, sen));
    idle(hold, outs_l3(cen, sen), "R3 R4 enables latched");
    wake_pulse(src);
    chk("R7 sleep released", {stpclk_n, cpustp_n, slp_n}, {1'b0, ~cen, 1'b1});
    for (int j = 1; j <= GAP; j++) begin
      if (j == 1 && spur) rd_pulse(4'd5, "R8");
      else step();
      chk("R7 cpu release step", {stpclk_n, cpustp_n, slp_n},
          {1'b0, (j == GAP) ? 1'b1 : ~cen, 1'b1});
    end
    for (int j = 1; j <= GAP; j++) begin
      step();
      chk("R7 stop-clock release step", {stpclk_n, cpustp_n, slp_n},
          {(j == GAP), 2'b11});
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    wait (cycles > 100000);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'd2024));
    step(); step();
    chk("R9 reset outputs", {stpclk_n, cpustp_n, slp_n}, 3'b111);
    rst_n = 1;
    step();
    chk("R9 running after reset", {stpclk_n, cpustp_n, slp_n}, 3'b111);

    wake_pulse(0);
    chk("R8 wake while running", {stpclk_n, cpustp_n, slp_n}, 3'b111);
    wake_pulse(2);
    chk("R8 wake while running", {stpclk_n, cpustp_n, slp_n}, 3'b111);

    for (int a = 4; a <= 5; a++) begin
      reg_addr = 4'(a); reg_wr = 1; reg_wdata = 32'hFFFF_FFFF;
      step();
      reg_wr = 0;
      chk("R6 write ignored", {stpclk_n, cpustp_n, slp_n}, 3'b111);
    end
    rd_pulse(4'd7, "R6");
    chk("R6 other read no entry", {stpclk_n, cpustp_n, slp_n}, 3'b111);

    run_l2(1, 2, 1);
    run_l3(1'b1, 1'b1, 0, 3, 1'b1);
    run_l3(1'b0, 1'b0, 2, 1, 1'b0);
    run_l3(1'b1, 1'b0, 1, 0, 1'b0);
    run_l3(1'b0, 1'b1, 0, 2, 1'b1);

    for (int k = 0; k < 60; k++) begin
      int src = $urandom % 3;
      int hold = $urandom % 6;
      bit spur = 1'($urandom);
      if ($urandom % 2) run_l2(src, hold, spur);
      else run_l3(1'($urandom), 1'($urandom), src, hold, spur);
      idle($urandom % 3, 3'b111, "R8 running idle");
    end
    report();
  end
endmodule